// File: doc/BRIEF.md
# Indexed CMOS Clock Register File

This block is the byte-wide register file of a real-time clock as seen by a processor over two adjacent I/O addresses. A write to the lower address selects a register. An access to the upper address then reads or writes the selected register. The selection stays in place until software changes it. The time of day comes from an external calendar counter. The block copies that time into a snapshot register at most once per second, so software can read seconds, minutes and hours one at a time and still get one consistent moment.

Each time field is formatted when it is read, according to two mode bits in the mode register. The first bit selects packed BCD or plain binary. The second selects a 12-hour or 24-hour clock. The block also holds an update/rate register, the mode register, two fixed status bytes, and 114 bytes of general storage. One storage byte is preloaded at reset with the century. An access that the block cannot honour returns a one-cycle error strobe and changes no state.

Top module: `cmos_regfile`

## Requirements
- R1: Only accesses to `BASE_ADDR` (index port) or `BASE_ADDR+1` (data port) get a response. Any other address produces neither `bus_rd_valid` nor `bus_err`. An access to either port whose `bus_bytes` is not 1 is rejected: `bus_err` pulses for one cycle and no state changes. Responses appear in the cycle after the request edge, and all outputs are 0 after reset.
- R2: A read of the index port returns 0xFF with `bus_rd_valid`.
- R3: An index write keeps `bus_wdata[6:0]`. Indices 0x01, 0x03 and 0x05 are not implemented; writing one of them raises `bus_err` and keeps the previous index. The index resets to 0x00 and persists across any number of data-port accesses.
- R4: The time registers sit at these indices: 0x00 seconds, 0x02 minutes, 0x04 hours, 0x06 weekday, 0x07 day of month, 0x08 month and 0x09 year. Weekday reads as input+1 (input 0..6), month as input+1 (input 0..11), and year as `cal_year` mod 100.
- R5: Mode register bit 2 = 1 returns time fields in binary. Bit 2 = 0 returns them in two-digit packed BCD (tens digit in bits 7:4).
- R6: Mode register bit 1 = 1 gives hours 0..23. Bit 1 = 0 gives 12-hour form: hour 0 reads 12, and hours 13..23 read 1..11. Bit 7 of the hours byte is set for hours 12..23, and it is ORed in after the BCD or binary conversion.
- R7: The snapshot loads in the first cycle after reset and afterwards only on a cycle with `sec_tick` high while mode bit 7 (halt) is 0. A data read in the same cycle as a tick returns the pre-tick snapshot. The tick is gated by the halt value held before any same-cycle write.
- R8: A write to index 0x0A stores the value with bit 7 cleared. Reading 0x0A returns the stored value.
- R9: A write to index 0x0B with bit 6 set is rejected with `bus_err` and the register is unchanged. Any other value is stored as written and reads back. The register resets to 0x00.
- R10: Index 0x0C always reads 0x00. Index 0x0D always reads 0x80. Writes to 0x0D and to the time registers are accepted without error and change nothing.
- R11: Indices 0x0E..0x7F read back the last value written. They reset to 0x00, except index 0x32, which resets to the century (`cal_year`/100) in BCD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | I/O request in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | I/O address |
| bus_bytes | input | 3 | Access size in bytes |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid with bus_rd_valid |
| bus_rd_valid | output | 1 | Read response strobe |
| bus_err | output | 1 | Reject strobe |
| sec_tick | input | 1 | One-cycle pulse once per second |
| cal_sec | input | 6 | Calendar seconds 0..59 |
| cal_min | input | 6 | Calendar minutes 0..59 |
| cal_hour | input | 5 | Calendar hour 0..23 |
| cal_wday | input | 3 | Day of week 0..6 |
| cal_mday | input | 5 | Day of month 1..31 |
| cal_mon | input | 4 | Month 0..11 |
| cal_year | input | 14 | Full year, 0..9999 |

## Verification
Two collisions can happen in the same cycle. The first is a data read that lands on the same edge as the one-second tick. The second is a write to the mode register that sets or clears halt on the same edge as a tick. Directed steps put a seconds read on the tick cycle and then read again, expecting the old value first and the new value second. They also write halt together with a tick and expect the snapshot to refresh anyway. The random phase overlaps ticks with every kind of access. A bench model judges each overlap: it first compares the response against the state before the edge, then applies the write, then refreshes its snapshot copy only if halt was clear before the write.

// File: rtl/cmos_pkg.sv
package cmos_pkg;

    localparam int IDX_W = 7;
    localparam logic [2:0] ONE_BYTE = 3'd1;

    // register indices (software-visible map)
    localparam logic [IDX_W-1:0] REG_SEC      = 7'h00;
    localparam logic [IDX_W-1:0] REG_MIN      = 7'h02;
    localparam logic [IDX_W-1:0] REG_HOUR     = 7'h04;
    localparam logic [IDX_W-1:0] REG_WDAY     = 7'h06;
    localparam logic [IDX_W-1:0] REG_MDAY     = 7'h07;
    localparam logic [IDX_W-1:0] REG_MON      = 7'h08;
    localparam logic [IDX_W-1:0] REG_YEAR     = 7'h09;
    localparam logic [IDX_W-1:0] REG_RATE     = 7'h0A;
    localparam logic [IDX_W-1:0] REG_MODE     = 7'h0B;
    localparam logic [IDX_W-1:0] REG_FLAGS    = 7'h0C;
    localparam logic [IDX_W-1:0] REG_POWER    = 7'h0D;
    localparam logic [IDX_W-1:0] REG_STORE_LO = 7'h0E;
    localparam logic [IDX_W-1:0] REG_CENTURY  = 7'h32;

    localparam int STORE_LO    = int'(REG_STORE_LO);
    localparam int STORE_DEPTH = (1 << IDX_W) - STORE_LO;

    // mode register bit positions
    localparam int MODE_24H_BIT  = 1;
    localparam int MODE_BIN_BIT  = 2;
    localparam int MODE_TICK_BIT = 6;
    localparam int MODE_HALT_BIT = 7;
    localparam int RATE_BUSY_BIT = 7;

    localparam logic [7:0] MODE_RESET   = 8'h00;
    localparam logic [7:0] RATE_RESET   = 8'h00;
    localparam logic [7:0] INDEX_RD_VAL = 8'hFF;
    localparam logic [7:0] FLAGS_VAL    = 8'h00;
    localparam logic [7:0] POWER_VAL    = 8'h80;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_INDEX = 2'd1,
        ACC_DATA  = 2'd2
    } acc_port_e;

    typedef struct packed {
        acc_port_e  port;
        logic       wr;
        logic       size_ok;
        logic [7:0] wdata;
    } bus_req_t;

    typedef struct packed {
        logic [5:0] sec;
        logic [5:0] min;
        logic [4:0] hour;
        logic [2:0] wday;
        logic [4:0] mday;
        logic [3:0] mon;
        logic [6:0] yr;
    } tod_t;

    function automatic logic [7:0] to_bcd(input logic [6:0] v);
        logic [7:0] r;
        r[7:4] = 4'(v / 7'd10);
        r[3:0] = 4'(v % 7'd10);
        return r;
    endfunction

    function automatic logic [7:0] encode(input logic [6:0] v, input logic bin);
        return bin ? {1'b0, v} : to_bcd(v);
    endfunction

    function automatic logic [7:0] fmt_hour(input logic [4:0] h, input logic h24,
                                            input logic bin);
        logic [6:0] disp;
        logic       pm;
        pm = 1'b0;
        if (h24) begin
            disp = {2'b00, h};
        end else begin
            pm = (h >= 5'd12);
            if (h == 5'd0)
                disp = 7'd12;
            else if (h > 5'd12)
                disp = 7'(h - 5'd12);
            else
                disp = {2'b00, h};
        end
        return encode(disp, bin) | {pm, 7'b0};
    endfunction

    function automatic logic index_known(input logic [IDX_W-1:0] idx);
        return (idx >= REG_STORE_LO) ||
               (idx inside {REG_SEC, REG_MIN, REG_HOUR, REG_WDAY, REG_MDAY,
                            REG_MON, REG_YEAR, REG_RATE, REG_MODE,
                            REG_FLAGS, REG_POWER});
    endfunction

endpackage

// File: rtl/cmos_port_decode.sv
module cmos_port_decode
    import cmos_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 'h70
) (
    input  logic              valid,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        bytes,
    input  logic [7:0]        wdata,
    output bus_req_t          req
);
    localparam logic [ADDR_W-1:0] DATA_ADDR = BASE_ADDR + 1'b1;

    always_comb begin
        req.port = ACC_NONE;
        if (valid) begin
            if (addr == BASE_ADDR)
                req.port = ACC_INDEX;
            else if (addr == DATA_ADDR)
                req.port = ACC_DATA;
        end
        req.wr      = write;
        req.size_ok = (bytes == ONE_BYTE);
        req.wdata   = wdata;
    end
endmodule

// File: rtl/cmos_index_reg.sv
module cmos_index_reg
    import cmos_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  bus_req_t         req,
    output logic [IDX_W-1:0] idx_q,
    output logic             idx_reject
);
    logic             idx_wr;
    logic [IDX_W-1:0] new_idx;

    assign new_idx    = req.wdata[IDX_W-1:0];
    assign idx_wr     = (req.port == ACC_INDEX) && req.wr && req.size_ok;
    assign idx_reject = idx_wr && !index_known(new_idx);

    always_ff @(posedge clk) begin
        if (rst)
            idx_q <= REG_SEC;
        else if (idx_wr && !idx_reject)
            idx_q <= new_idx;
    end
endmodule

// File: rtl/cmos_tod_snapshot.sv
module cmos_tod_snapshot
    import cmos_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sec_tick,
    input  logic halt,
    input  tod_t live,
    output tod_t snap_q,
    output logic primed_q
);
    // first cycle out of reset always loads; afterwards only on an unhalted tick
    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q   <= '0;
            primed_q <= 1'b0;
        end else begin
            primed_q <= 1'b1;
            if (!primed_q || (sec_tick && !halt))
                snap_q <= live;
        end
    end
endmodule

// File: rtl/cmos_store.sv
module cmos_store
    import cmos_pkg::*;
#(
    parameter int LO    = STORE_LO,
    parameter int DEPTH = STORE_DEPTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       wdata,
    input  logic [7:0]       init_century,
    output logic [7:0]       rd_byte
);
    localparam int CENT_SLOT = int'(REG_CENTURY) - LO;

    logic [7:0]       cells [DEPTH];
    logic [IDX_W-1:0] slot;

    assign slot    = idx - IDX_W'(LO);
    assign rd_byte = cells[slot];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                cells[i] <= (i == CENT_SLOT) ? init_century : 8'h00;
        end else if (wr_en) begin
            cells[slot] <= wdata;
        end
    end
endmodule

// File: rtl/cmos_regfile.sv
module cmos_regfile
    import cmos_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 'h70
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [2:0]        bus_bytes,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              bus_rd_valid,
    output logic              bus_err,
    input  logic              sec_tick,
    input  logic [5:0]        cal_sec,
    input  logic [5:0]        cal_min,
    input  logic [4:0]        cal_hour,
    input  logic [2:0]        cal_wday,
    input  logic [4:0]        cal_mday,
    input  logic [3:0]        cal_mon,
    input  logic [13:0]       cal_year
);
    bus_req_t         req;
    logic [IDX_W-1:0] idx_q;
    logic             idx_reject;
    tod_t             live;
    tod_t             snap_q;
    logic             snap_primed;
    logic [7:0]       stat_a_q;
    logic [7:0]       stat_b_q;
    logic [7:0]       store_byte;
    logic [7:0]       century_enc;
    logic [7:0]       rd_byte;
    logic             data_wr;
    logic             mode_reject;
    logic             size_reject;
    logic             rd_go;
    logic             fmt_bin;
    logic             fmt_24h;

    cmos_port_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
        .valid (bus_valid),
        .write (bus_write),
        .addr  (bus_addr),
        .bytes (bus_bytes),
        .wdata (bus_wdata),
        .req   (req)
    );

    cmos_index_reg u_idx (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .idx_q      (idx_q),
        .idx_reject (idx_reject)
    );

    always_comb begin
        live.sec  = cal_sec;
        live.min  = cal_min;
        live.hour = cal_hour;
        live.wday = cal_wday;
        live.mday = cal_mday;
        live.mon  = cal_mon;
        live.yr   = 7'(cal_year % 14'd100);
    end

    cmos_tod_snapshot u_snap (
        .clk      (clk),
        .rst      (rst),
        .sec_tick (sec_tick),
        .halt     (stat_b_q[MODE_HALT_BIT]),
        .live     (live),
        .snap_q   (snap_q),
        .primed_q (snap_primed)
    );

    // century preload uses the mode that holds during reset
    assign century_enc = encode(7'(cal_year / 14'd100), MODE_RESET[MODE_BIN_BIT]);

    assign size_reject = (req.port != ACC_NONE) && !req.size_ok;
    assign data_wr     = (req.port == ACC_DATA) && req.wr && req.size_ok;
    assign mode_reject = data_wr && (idx_q == REG_MODE) && req.wdata[MODE_TICK_BIT];
    assign rd_go       = (req.port != ACC_NONE) && !req.wr && req.size_ok;

    cmos_store u_store (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (data_wr && (idx_q >= REG_STORE_LO)),
        .idx          (idx_q),
        .wdata        (req.wdata),
        .init_century (century_enc),
        .rd_byte      (store_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_a_q <= RATE_RESET;
            stat_b_q <= MODE_RESET;
        end else if (data_wr) begin
            if (idx_q == REG_RATE)
                stat_a_q <= req.wdata & ~(8'h01 << RATE_BUSY_BIT);
            if ((idx_q == REG_MODE) && !mode_reject)
                stat_b_q <= req.wdata;
        end
    end

    assign fmt_bin = stat_b_q[MODE_BIN_BIT];
    assign fmt_24h = stat_b_q[MODE_24H_BIT];

    always_comb begin
        case (idx_q)
            REG_SEC:   rd_byte = encode({1'b0, snap_q.sec}, fmt_bin);
            REG_MIN:   rd_byte = encode({1'b0, snap_q.min}, fmt_bin);
            REG_HOUR:  rd_byte = fmt_hour(snap_q.hour, fmt_24h, fmt_bin);
            REG_WDAY:  rd_byte = encode({4'b0, snap_q.wday} + 7'd1, fmt_bin);
            REG_MDAY:  rd_byte = encode({2'b0, snap_q.mday}, fmt_bin);
            REG_MON:   rd_byte = encode({3'b0, snap_q.mon} + 7'd1, fmt_bin);
            REG_YEAR:  rd_byte = encode(snap_q.yr, fmt_bin);
            REG_RATE:  rd_byte = stat_a_q;
            REG_MODE:  rd_byte = stat_b_q;
            REG_FLAGS: rd_byte = FLAGS_VAL;
            REG_POWER: rd_byte = POWER_VAL;
            default:   rd_byte = store_byte;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata    <= 8'h00;
            bus_rd_valid <= 1'b0;
            bus_err      <= 1'b0;
        end else begin
            bus_rd_valid <= rd_go;
            bus_err      <= size_reject || idx_reject || mode_reject;
            if (rd_go)
                bus_rdata <= (req.port == ACC_INDEX) ? INDEX_RD_VAL : rd_byte;
        end
    end
endmodule

// File: rtl/cmos_regfile_chk.sv
module cmos_regfile_chk
    import cmos_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 'h70
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [2:0]        bus_bytes,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic              bus_rd_valid,
    input logic              bus_err,
    input logic [IDX_W-1:0]  idx_q,
    input tod_t              snap_q,
    input logic              snap_primed,
    input logic [7:0]        mode_q
);
    localparam logic [ADDR_W-1:0] DATA_ADDR = BASE_ADDR + 1'b1;

    logic hit_any, one_b;
    assign hit_any = bus_valid && ((bus_addr == BASE_ADDR) || (bus_addr == DATA_ADDR));
    assign one_b   = (bus_bytes == ONE_BYTE);

    assert_no_resp_R1: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !hit_any) |=> (!bus_rd_valid && !bus_err));

    assert_size_reject_R1: assert property (@(posedge clk) disable iff (rst)
        (hit_any && !one_b) |=> (bus_err && !bus_rd_valid));

    assert_index_read_ff_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_write && bus_addr == BASE_ADDR && one_b)
        |=> (bus_rd_valid && bus_rdata == 8'hFF));

    assert_bad_index_kept_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_write && bus_addr == BASE_ADDR && one_b &&
         (bus_wdata[6:0] inside {7'h01, 7'h03, 7'h05}))
        |=> (bus_err && $stable(idx_q)));

    assert_halt_freeze_R7: assert property (@(posedge clk) disable iff (rst)
        (snap_primed && mode_q[MODE_HALT_BIT]) |=> $stable(snap_q));

    assert_mode_tick_reject_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_write && bus_addr == DATA_ADDR && one_b &&
         idx_q == REG_MODE && bus_wdata[MODE_TICK_BIT])
        |=> (bus_err && $stable(mode_q)));

    assert_flags_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_write && bus_addr == DATA_ADDR && one_b && idx_q == REG_FLAGS)
        |=> (bus_rd_valid && bus_rdata == 8'h00));

    assert_power_good_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_write && bus_addr == DATA_ADDR && one_b && idx_q == REG_POWER)
        |=> (bus_rd_valid && bus_rdata == 8'h80));

    assert_rate_busy_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_write && bus_addr == DATA_ADDR && one_b && idx_q == REG_RATE)
        |=> (bus_rd_valid && !bus_rdata[7]));
endmodule

bind cmos_regfile cmos_regfile_chk #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_valid    (bus_valid),
    .bus_write    (bus_write),
    .bus_addr     (bus_addr),
    .bus_bytes    (bus_bytes),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .bus_rd_valid (bus_rd_valid),
    .bus_err      (bus_err),
    .idx_q        (idx_q),
    .snap_q       (snap_q),
    .snap_primed  (snap_primed),
    .mode_q       (stat_b_q)
);

// File: tb/cmos_regfile_test.sv
module cmos_regfile_test;

    localparam logic [15:0] BASE = 16'h0070;
    localparam logic [15:0] DATA = 16'h0071;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [15:0] bus_addr = 16'h0;
    logic [2:0]  bus_bytes = 3'd1;
    logic [7:0]  bus_wdata = 8'h0;
    logic [7:0]  bus_rdata;
    logic        bus_rd_valid;
    logic        bus_err;
    logic        sec_tick = 1'b0;
    logic [5:0]  cal_sec = 6'd0;
    logic [5:0]  cal_min = 6'd0;
    logic [4:0]  cal_hour = 5'd0;
    logic [2:0]  cal_wday = 3'd0;
    logic [4:0]  cal_mday = 5'd1;
    logic [3:0]  cal_mon = 4'd0;
    logic [13:0] cal_year = 14'd2000;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // bench model
    int         s_sec, s_min, s_hour, s_wday, s_mday, s_mon, s_year;
    logic [7:0] m_sta, m_stb;
    logic [6:0] m_idx;
    logic [7:0] m_store [128];
    logic [7:0] got_rdata;
    logic       got_rv, got_err;

    always #2 clk = ~clk;

    cmos_regfile uut (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_bytes(bus_bytes), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rd_valid(bus_rd_valid), .bus_err(bus_err),
        .sec_tick(sec_tick), .cal_sec(cal_sec), .cal_min(cal_min),
        .cal_hour(cal_hour), .cal_wday(cal_wday), .cal_mday(cal_mday),
        .cal_mon(cal_mon), .cal_year(cal_year)
    );

    task automatic check8(input string rq, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", rq, act, exp);
        end
    endtask

    function automatic logic [7:0] fmt(input int v);
        if (m_stb[2]) return 8'(v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic logic [7:0] exp_data(input int ix);
        int h;
        case (ix)
            'h00: return fmt(s_sec);
            'h02: return fmt(s_min);
            'h04: begin
                if (m_stb[1]) return fmt(s_hour);
                h = s_hour % 12;
                if (h == 0) h = 12;
                return fmt(h) | ((s_hour >= 12) ? 8'h80 : 8'h00);
            end
            'h06: return fmt(s_wday + 1);
            'h07: return fmt(s_mday);
            'h08: return fmt(s_mon + 1);
            'h09: return fmt(s_year % 100);
            'h0A: return m_sta;
            'h0B: return m_stb;
            'h0C: return 8'h00;
            'h0D: return 8'h80;
            default: return m_store[ix];
        endcase
    endfunction

    function automatic bit known(input int ix);
        return (ix >= 'h0E) || (ix inside {0, 2, 4, 6, 7, 8, 9, 'h0A, 'h0B, 'h0C, 'h0D});
    endfunction

    function automatic string tag_of(input logic [15:0] a, input logic w, input int nb,
                                     input int ix);
        if ((a != BASE && a != DATA) || nb != 1) return "R1";
        if (a == BASE) return w ? "R3" : "R2";
        case (ix)
            'h00, 'h02: return "R5";
            'h04: return "R6";
            'h06, 'h07, 'h08, 'h09: return "R4";
            'h0A: return "R8";
            'h0B: return "R9";
            'h0C, 'h0D: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic take_snap();
        s_sec = cal_sec; s_min = cal_min; s_hour = cal_hour; s_wday = cal_wday;
        s_mday = cal_mday; s_mon = cal_mon; s_year = cal_year;
    endtask

    // one bus cycle with model prediction, compare, then model update
    task automatic op(input logic [15:0] a, input logic w, input int nb,
                      input logic [7:0] d, input logic tk, input string force_tag);
        bit    hit, halt_before, exp_rv, exp_err;
        logic [7:0] exp_rd;
        string tg;
        hit = (a == BASE) || (a == DATA);
        halt_before = m_stb[7];
        exp_rv = 0; exp_err = 0; exp_rd = 8'h00;
        tg = (force_tag != "") ? force_tag : tag_of(a, w, nb, int'(m_idx));
        if (hit && nb != 1) exp_err = 1;
        else if (hit && a == BASE) begin
            if (w) exp_err = !known(int'(d[6:0]));
            else begin exp_rv = 1; exp_rd = 8'hFF; end
        end else if (hit) begin
            if (w) exp_err = (m_idx == 7'h0B) && d[6];
            else begin exp_rv = 1; exp_rd = exp_data(int'(m_idx)); end
        end
        @(negedge clk);
        bus_valid = 1'b1; bus_write = w; bus_addr = a; bus_bytes = 3'(nb);
        bus_wdata = d; sec_tick = tk;
        @(posedge clk);
        #1;
        got_rdata = bus_rdata; got_rv = bus_rd_valid; got_err = bus_err;
        bus_valid = 1'b0; sec_tick = 1'b0;
        check8({tg, " rd_valid"}, {7'b0, got_rv}, {7'b0, exp_rv});
        check8({tg, " err"}, {7'b0, got_err}, {7'b0, exp_err});
        if (exp_rv) check8({tg, " rdata"}, got_rdata, exp_rd);
        if (hit && nb == 1 && w && !exp_err) begin
            if (a == BASE) m_idx = d[6:0];
            else if (m_idx == 7'h0A) m_sta = d & 8'h7F;
            else if (m_idx == 7'h0B) m_stb = d;
            else if (m_idx >= 7'h0E) m_store[m_idx] = d;
        end
        if (tk && !halt_before) take_snap();
    endtask

    task automatic sel(input int ix);
        op(BASE, 1'b1, 1, 8'(ix), 1'b0, "R3");
    endtask

    task automatic rd(input int ix, input string tg);
        sel(ix);
        op(DATA, 1'b0, 1, 8'h00, 1'b0, tg);
    endtask

    task automatic wr(input int ix, input logic [7:0] d);
        sel(ix);
        op(DATA, 1'b1, 1, d, 1'b0, "");
    endtask

    task automatic set_cal(input int y, input int mo, input int md, input int wd,
                           input int h, input int mi, input int s);
        cal_year = 14'(y); cal_mon = 4'(mo); cal_mday = 5'(md); cal_wday = 3'(wd);
        cal_hour = 5'(h); cal_min = 6'(mi); cal_sec = 6'(s);
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        report();
    end

    initial begin
        int r, ix;
        void'($urandom(32'd20240611));
        set_cal(2024, 11, 31, 6, 23, 59, 58);
        for (int i = 0; i < 128; i++) m_store[i] = 8'h00;
        m_store['h32] = 8'h20;
        m_sta = 8'h00; m_stb = 8'h00; m_idx = 7'h00;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        take_snap();
        // reset outputs (R1)
        check8("R1 reset rd_valid", {7'b0, bus_rd_valid}, 8'h00);
        check8("R1 reset err", {7'b0, bus_err}, 8'h00);

        // R3: index persists from reset at 0x00; data read twice
        op(DATA, 1'b0, 1, 8'h00, 1'b0, "R3");
        check8("R5 seconds bcd", got_rdata, 8'h58);
        op(DATA, 1'b0, 1, 8'h00, 1'b0, "R3");
        // R2: index port read
        op(BASE, 1'b0, 1, 8'h00, 1'b0, "R2");
        // R3: unimplemented index rejected, index kept
        op(BASE, 1'b1, 1, 8'h03, 1'b0, "R3");
        op(DATA, 1'b0, 1, 8'h00, 1'b0, "R3");
        // R3: upper bit of index byte dropped
        op(BASE, 1'b1, 1, 8'h84, 1'b0, "R3");
        op(DATA, 1'b0, 1, 8'h00, 1'b0, "R6");
        check8("R6 hour 23 in 12h bcd", got_rdata, 8'h91);
        // R11 century preload and reset zero
        rd('h32, "R11"); check8("R11 century", got_rdata, 8'h20);
        rd('h7F, "R11");
        // R4 field mapping
        rd('h06, "R4"); check8("R4 weekday", got_rdata, 8'h07);
        rd('h08, "R4"); check8("R4 month", got_rdata, 8'h12);
        rd('h09, "R4"); check8("R4 year", got_rdata, 8'h24);
        // R5/R6 mode combos
        wr('h0B, 8'h06); rd('h04, "R6"); check8("R6 24h bin", got_rdata, 8'h17);
        wr('h0B, 8'h04); rd('h04, "R6"); check8("R6 12h bin pm", got_rdata, 8'h8B);
        wr('h0B, 8'h02); rd('h04, "R6"); check8("R6 24h bcd", got_rdata, 8'h23);
        wr('h0B, 8'h04); rd('h07, "R5");
        // R9 tick-enable rejected
        wr('h0B, 8'h44); rd('h0B, "R9"); check8("R9 kept", got_rdata, 8'h04);
        wr('h0B, 8'h00);
        // R6 hour 0 and hour 12 in 12h mode
        set_cal(2024, 0, 1, 0, 0, 0, 0);
        op(BASE, 1'b1, 1, 8'h04, 1'b1, "R7");
        op(DATA, 1'b0, 1, 8'h00, 1'b0, "R6"); check8("R6 midnight", got_rdata, 8'h12);
        set_cal(2024, 0, 1, 0, 12, 0, 0);
        op(BASE, 1'b1, 1, 8'h04, 1'b1, "R7");
        op(DATA, 1'b0, 1, 8'h00, 1'b0, "R6"); check8("R6 noon", got_rdata, 8'h92);
        // R7 read on tick cycle returns old snapshot
        set_cal(2024, 0, 1, 0, 12, 0, 30);
        sel('h00);
        op(DATA, 1'b0, 1, 8'h00, 1'b1, "R7"); check8("R7 old on tick", got_rdata, 8'h00);
        op(DATA, 1'b0, 1, 8'h00, 1'b0, "R7"); check8("R7 new after tick", got_rdata, 8'h30);
        // R7 halt: write halt on a tick cycle still refreshes, then frozen
        set_cal(2024, 0, 1, 0, 12, 0, 41);
        sel('h0B);
        op(DATA, 1'b1, 1, 8'h80, 1'b1, "R7");
        set_cal(2024, 0, 1, 0, 12, 0, 45);
        op(DATA, 1'b0, 1, 8'h00, 1'b1, "R7");
        rd('h00, "R7"); check8("R7 halted", got_rdata, 8'h41);
        wr('h0B, 8'h00);
        op(BASE, 1'b1, 1, 8'h00, 1'b1, "R7");
        op(DATA, 1'b0, 1, 8'h00, 1'b0, "R7"); check8("R7 resumed", got_rdata, 8'h45);
        // R8
        wr('h0A, 8'hFF); rd('h0A, "R8"); check8("R8 busy cleared", got_rdata, 8'h7F);
        // R10
        rd('h0C, "R10"); wr('h0D, 8'h00); rd('h0D, "R10");
        wr('h00, 8'h11); rd('h00, "R10"); check8("R10 time write ignored", got_rdata, 8'h45);
        // R11 store
        wr('h0E, 8'hA5); wr('h7F, 8'h3C); rd('h0E, "R11"); rd('h7F, "R11");
        // R1 size and address
        op(DATA, 1'b1, 2, 8'hFF, 1'b0, "R1");
        op(BASE, 1'b1, 4, 8'h0E, 1'b0, "R1");
        op(DATA, 1'b0, 1, 8'h00, 1'b0, "R11"); check8("R1 size reject no change", got_rdata, 8'h3C);
        op(16'h0072, 1'b0, 1, 8'h00, 1'b0, "R1");
        op(16'h0170, 1'b1, 1, 8'h0E, 1'b0, "R1");

        // constrained random phase
        for (int n = 0; n < 600; n++) begin
            r = $urandom % 12;
            if (r == 0)
                set_cal(1900 + $urandom % 200, $urandom % 12, 1 + $urandom % 31,
                        $urandom % 7, $urandom % 24, $urandom % 60, $urandom % 60);
            else if (r <= 2) begin
                ix = ($urandom % 4 == 0) ? $urandom % 128 : $urandom % 16;
                op(BASE, 1'b1, 1, 8'(ix | (($urandom % 2) << 7)), ($urandom % 6) == 0, "");
            end else if (r <= 6)
                op(DATA, 1'b0, 1, 8'h00, ($urandom % 5) == 0, "");
            else if (r <= 8)
                op(DATA, 1'b1, 1, 8'($urandom), ($urandom % 5) == 0, "");
            else if (r == 9)
                op(($urandom % 2) ? BASE : DATA, $urandom % 2, ($urandom % 2) ? 0 : 2,
                   8'($urandom), 1'b0, "R1");
            else if (r == 10)
                op(BASE, 1'b0, 1, 8'h00, ($urandom % 2) == 1, "R2");
            else
                op(DATA, 1'b0, 1, 8'h00, 1'b1, "R7");
        end
        report();
    end
endmodule